// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Length

This block is one transmit channel of an asynchronous serial port. Software writes a character into a one-deep holding register; on the next 16x clock enable the character moves into the shift register and is sent as a start bit, 5 to 8 data bits least significant first, an optional parity bit and a stop period. Every line element is timed in sixteenths of a bit on the `tick16` enable. No baud generator and no receiver are included.

The stop period is set in sixteenths of a bit by a 4-bit code. Single-cycle command pulses switch the transmitter on and off, empty it, and start or end a break. An optional clear-to-send input gates the start of each new character. Two status outputs report an empty holding register and a fully drained channel.

Top module: `uart_frac_tx`

## Requirements
- R1: After `rst`, `txd` is 1, the transmitter is off (`tx_rdy` = 0) and `tx_emt` = 1.
- R2: A frame is a 0 start bit, then `cfg_len`+5 data bits LSB first (`cfg_len` 0..3 gives 5..8 bits; data bits above the length are dropped), each element lasting 16 ticks of `tick16`.
- R3: `cfg_par_mode` 0 appends a parity bit equal to the XOR of the data bits XOR `cfg_par_odd` (0 even, 1 odd); mode 1 appends a fixed bit equal to `cfg_par_odd`; modes 2 and 3 append no parity bit.
- R4: The stop period is high for 9+code ticks for `cfg_stop` codes 0..7 and for 17+code ticks for codes 8..15.
- R5: With 5-bit characters (`cfg_len` = 0), codes 0..7 lengthen the stop period by 8 ticks; codes 8..15 are unchanged.
- R6: `tx_rdy` is 1 when the transmitter is on and the holding register is empty; `tx_emt` is 1 when both the holding and shift registers are empty. A waiting character starts on the tick that ends the previous stop period, with no idle gap.
- R7: A write while the transmitter is off is dropped: nothing is sent and `tx_emt` stays 1, even after it is switched on again.
- R8: Switching the transmitter off while a character is on the line lets that character finish; a character waiting in the holding register is not started and the line stays high.
- R9: `cmd_tx_reset` empties both registers and cancels any break, so `txd` and `tx_emt` are 1 in the next cycle.
- R10: `cmd_brk_start` lets the character in progress finish its stop period and then holds `txd` low.
- R11: `cmd_brk_stop` ends the break with exactly one bit time (16 ticks) high, after which transmission resumes.
- R12: With `cfg_cts_en` = 1, no new character starts while `cts_i` is 0; it starts once `cts_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at sixteen times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par_mode | input | 2 | 0 computed parity, 1 fixed parity, 2/3 none |
| cfg_par_odd | input | 1 | Odd parity, or fixed parity bit value |
| cfg_stop | input | 4 | Stop length code in sixteenths of a bit |
| cfg_cts_en | input | 1 | Gate new characters on `cts_i` |
| cts_i | input | 1 | Clear to send, active high |
| cmd_tx_on | input | 1 | Pulse: switch transmitter on |
| cmd_tx_off | input | 1 | Pulse: switch transmitter off |
| cmd_tx_reset | input | 1 | Pulse: empty both registers, line high |
| cmd_brk_start | input | 1 | Pulse: start break after current character |
| cmd_brk_stop | input | 1 | Pulse: end break |
| txd | output | 1 | Serial line, idle high |
| tx_rdy | output | 1 | Holding register empty and transmitter on |
| tx_emt | output | 1 | Holding and shift registers both empty |

## Verification
The bench builds the block with its default 8-bit data path and sixteen ticks per bit, and drives `tick16` on every third clock so that each line element lasts an exact, non-trivial number of clocks and line timing can be counted at the pins. That makes the exact stop length of every code class measurable as the high run between two back-to-back frames, including the 5-bit extension and its absence above code 7. The same counting shows the break starting right after the stop period and the single high bit before the next character.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    localparam int DATA_W  = 8;
    localparam int SUBDIV  = 16;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = 6;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MIN_LEN = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK,
        S_MARK
    } ser_state_e;

    typedef enum logic [1:0] {
        PAR_CALC  = 2'd0,
        PAR_FIXED = 2'd1,
        PAR_OFF   = 2'd2,
        PAR_OFF2  = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic [IDX_W-1:0]  last_idx;
        logic              par_on;
        logic              par_val;
        logic [CNT_W-1:0]  stop_len;
    } frame_s;

    function automatic logic [DATA_W-1:0] char_mask(input logic [1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < int'(len) + MIN_LEN);
        end
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] stop_ticks(input logic [CODE_W-1:0] code,
                                                    input logic [1:0] len);
        logic [CNT_W-1:0] ext;
        logic [CNT_W-1:0] res;
        ext = {{(CNT_W-CODE_W){1'b0}}, code};
        if (code[CODE_W-1]) begin
            res = CNT_W'(SUBDIV + 1) + ext;
        end else begin
            res = CNT_W'(SUBDIV/2 + 1) + ext;
            if (len == 2'd0) begin
                res = res + CNT_W'(SUBDIV/2);
            end
        end
        return res;
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input par_mode_e mode,
                                       input logic odd);
        return (mode == PAR_FIXED) ? odd : ((^d) ^ odd);
    endfunction

    function automatic frame_s build_frame(input logic [DATA_W-1:0] d,
                                           input logic [1:0] len,
                                           input par_mode_e mode,
                                           input logic odd,
                                           input logic [CODE_W-1:0] code);
        frame_s f;
        f.bits     = d & char_mask(len);
        f.last_idx = IDX_W'(int'(len) + MIN_LEN - 1);
        f.par_on   = (mode == PAR_CALC) || (mode == PAR_FIXED);
        f.par_val  = parity_of(f.bits, mode, odd);
        f.stop_len = stop_ticks(code, len);
        return f;
    endfunction

endpackage

// File: rtl/ftx_holding.sv
module ftx_holding
    import ftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (pop) begin
                full <= 1'b0;
            end
            if (push) begin
                full <= 1'b1;
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/ftx_serializer.sv
module ftx_serializer
    import ftx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   tick,
    input  logic   load_ok,
    input  frame_s next_frame,
    input  logic   brk_set,
    input  logic   brk_clr,
    output logic   take,
    output logic   busy,
    output logic   brk_pend,
    output logic   line
);

    ser_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_idx;
    frame_s           cur;
    logic             cnt_last;
    logic             at_gap;

    // End of the current element, measured in ticks
    always_comb begin
        case (st)
            S_START, S_DATA, S_PAR, S_MARK: cnt_last = (cnt == CNT_W'(SUBDIV - 1));
            S_STOP:                         cnt_last = (cnt == cur.stop_len - CNT_W'(1));
            default:                        cnt_last = 1'b0;
        endcase
    end

    // Points where a new character may begin
    assign at_gap = (st == S_IDLE) || (cnt_last && ((st == S_STOP) || (st == S_MARK)));
    assign take   = tick && load_ok && !brk_pend && at_gap;
    assign busy   = (st != S_IDLE);

    always_comb begin
        case (st)
            S_START, S_BRK: line = 1'b0;
            S_DATA:         line = cur.bits[0];
            S_PAR:          line = cur.par_val;
            default:        line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st       <= S_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            cur      <= '0;
            brk_pend <= 1'b0;
        end else begin
            if (brk_clr) begin
                brk_pend <= 1'b0;
            end else if (brk_set) begin
                brk_pend <= 1'b1;
            end
            if (tick) begin
                if (take) begin
                    st      <= S_START;
                    cnt     <= '0;
                    bit_idx <= '0;
                    cur     <= next_frame;
                end else begin
                    case (st)
                        S_IDLE: begin
                            if (brk_pend) begin
                                st  <= S_BRK;
                                cnt <= '0;
                            end
                        end
                        S_START: begin
                            if (cnt_last) begin
                                st  <= S_DATA;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        S_DATA: begin
                            if (cnt_last) begin
                                cnt      <= '0;
                                cur.bits <= cur.bits >> 1;
                                if (bit_idx == cur.last_idx) begin
                                    st <= cur.par_on ? S_PAR : S_STOP;
                                end else begin
                                    bit_idx <= bit_idx + IDX_W'(1);
                                end
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        S_PAR: begin
                            if (cnt_last) begin
                                st  <= S_STOP;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        S_STOP, S_MARK: begin
                            if (cnt_last) begin
                                cnt <= '0;
                                st  <= brk_pend ? S_BRK : S_IDLE;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        S_BRK: begin
                            if (!brk_pend) begin
                                st  <= S_MARK;
                                cnt <= '0;
                            end
                        end
                        default: st <= S_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
    import ftx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  cfg_len,
    input  logic [1:0]  cfg_par_mode,
    input  logic        cfg_par_odd,
    input  logic [3:0]  cfg_stop,
    input  logic        cfg_cts_en,
    input  logic        cts_i,
    input  logic        cmd_tx_on,
    input  logic        cmd_tx_off,
    input  logic        cmd_tx_reset,
    input  logic        cmd_brk_start,
    input  logic        cmd_brk_stop,
    output logic        txd,
    output logic        tx_rdy,
    output logic        tx_emt
);

    logic              tx_on;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              push;
    logic              take;
    logic              load_ok;
    logic              ser_busy;
    logic              brk_pend;
    frame_s            next_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_on <= 1'b0;
        end else if (cmd_tx_off) begin
            tx_on <= 1'b0;
        end else if (cmd_tx_on) begin
            tx_on <= 1'b1;
        end
    end

    assign push    = wr_en && tx_on && !hold_full && !cmd_tx_reset;
    assign load_ok = hold_full && tx_on && (!cfg_cts_en || cts_i);

    assign next_frame = build_frame(hold_data, cfg_len, par_mode_e'(cfg_par_mode),
                                    cfg_par_odd, cfg_stop);

    ftx_holding u_hold (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd_tx_reset),
        .push  (push),
        .pop   (take),
        .din   (wr_data),
        .full  (hold_full),
        .dout  (hold_data)
    );

    ftx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .clear      (cmd_tx_reset),
        .tick       (tick16),
        .load_ok    (load_ok),
        .next_frame (next_frame),
        .brk_set    (cmd_brk_start),
        .brk_clr    (cmd_brk_stop),
        .take       (take),
        .busy       (ser_busy),
        .brk_pend   (brk_pend),
        .line       (txd)
    );

    assign tx_rdy = tx_on && !hold_full;
    assign tx_emt = !hold_full && !ser_busy;

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
    input logic clk,
    input logic rst,
    input logic cmd_tx_reset,
    input logic wr_en,
    input logic tx_rdy,
    input logic tx_emt,
    input logic txd,
    input logic cfg_cts_en,
    input logic cts_i,
    input logic ser_busy,
    input logic brk_pend
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        (rst || cmd_tx_reset) |=> (txd && tx_emt)); // R9

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_rdy && !cmd_tx_reset) |=> !tx_emt); // R6

    AST_OFF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_rdy && tx_emt && !brk_pend && !cmd_tx_reset) |=> tx_emt); // R7

    AST_CTS_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (cfg_cts_en && !cts_i && !ser_busy && !brk_pend) |=> txd); // R12

endmodule

bind uart_frac_tx ftx_checker u_ftx_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_tx_reset (cmd_tx_reset),
    .wr_en        (wr_en),
    .tx_rdy       (tx_rdy),
    .tx_emt       (tx_emt),
    .txd          (txd),
    .cfg_cts_en   (cfg_cts_en),
    .cts_i        (cts_i),
    .ser_busy     (ser_busy),
    .brk_pend     (brk_pend)
);

// File: tb/uart_frac_tx_bench.sv
module uart_frac_tx_bench;

    localparam int TICK_DIV = 3;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic [1:0] tdiv = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par_mode = 2'd2;
    logic       cfg_par_odd = 1'b0;
    logic [3:0] cfg_stop = 4'd7;
    logic       cfg_cts_en = 1'b0;
    logic       cts_i = 1'b1;
    logic       cmd_tx_on = 1'b0, cmd_tx_off = 1'b0, cmd_tx_reset = 1'b0;
    logic       cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0;
    logic       txd, tx_rdy, tx_emt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd2);

    uart_frac_tx u_uart_frac_tx (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
        .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cts_i(cts_i),
        .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off), .cmd_tx_reset(cmd_tx_reset),
        .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
        .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 on, 1 off, 2 reset, 3 break start, 4 break stop
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_tx_on = 1'b1;
            1: cmd_tx_off = 1'b1;
            2: cmd_tx_reset = 1'b1;
            3: cmd_brk_start = 1'b1;
            default: cmd_brk_stop = 1'b1;
        endcase
        @(negedge clk);
        cmd_tx_on = 1'b0; cmd_tx_off = 1'b0; cmd_tx_reset = 1'b0;
        cmd_brk_start = 1'b0; cmd_brk_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] d, input bit wait_rdy);
        @(negedge clk);
        if (wait_rdy) begin
            for (int i = 0; i < 3000 && !tx_rdy; i++) @(negedge clk);
        end
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setcfg(input logic [1:0] len, input logic [1:0] pm,
                          input logic odd, input logic [3:0] stop);
        cfg_len = len; cfg_par_mode = pm; cfg_par_odd = odd; cfg_stop = stop;
    endtask

    task automatic get_frame(input string req, input int nb, input bit has_par, input int cap,
                             output logic [7:0] d, output logic p, output int stop_cyc);
        int t = 0;
        d = 8'h00; p = 1'b0; stop_cyc = -1;
        while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
        chk({req, " start seen"}, int'(t < 4000), 1);
        if (t >= 4000) return;
        repeat (BIT_CYC/2) @(negedge clk);
        chk({req, " start bit low"}, int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            d[i] = txd;
        end
        if (has_par) begin
            repeat (BIT_CYC) @(negedge clk);
            p = txd;
        end
        repeat (BIT_CYC/2) @(negedge clk);
        stop_cyc = 0;
        while (txd === 1'b1 && stop_cyc < cap) begin stop_cyc++; @(negedge clk); end
    endtask

    task automatic t_reset();
        chk("R1 txd", int'(txd), 1);
        chk("R1 tx_rdy", int'(tx_rdy), 0);
        chk("R1 tx_emt", int'(tx_emt), 1);
    endtask

    task automatic t_ready_flags();
        int t = 0;
        pulse(0);
        chk("R6 rdy after on", int'(tx_rdy), 1);
        put(8'h3C, 0);
        chk("R6 rdy with hold full", int'(tx_rdy), 0);
        chk("R6 emt with hold full", int'(tx_emt), 0);
        repeat (4) @(negedge clk);
        chk("R6 rdy after move", int'(tx_rdy), 1);
        chk("R6 emt while shifting", int'(tx_emt), 0);
        put(8'hC3, 0);
        chk("R6 rdy second char", int'(tx_rdy), 0);
        while (!tx_emt && t < 3000) begin @(negedge clk); t++; end
        chk("R6 drained", int'(tx_emt), 1);
        chk("R6 rdy drained", int'(tx_rdy), 1);
    endtask

    task automatic t_pair(input string req, input logic [1:0] len, input logic [3:0] code,
                          input logic [7:0] a, input logic [7:0] b, input int exp_stop);
        logic [7:0] da, db; logic pa, pb; int sa, sb;
        logic [7:0] m;
        m = 8'hFF >> (3 - len);
        setcfg(len, 2'd2, 1'b0, code);
        fork
            begin
                get_frame(req, int'(len) + 5, 0, 200, da, pa, sa);
                get_frame(req, int'(len) + 5, 0, 120, db, pb, sb);
            end
            begin put(a, 1); put(b, 1); end
        join
        chk({req, " stop ticks x3 / R6 back-to-back"}, sa, exp_stop);
        chk({req, " data a R2"}, int'(da), int'(a & m));
        chk({req, " data b R2"}, int'(db), int'(b & m));
    endtask

    task automatic t_parity(input string req, input logic [1:0] len, input logic [1:0] pm,
                            input logic odd, input logic [7:0] a);
        logic [7:0] d, m; logic p; int s; logic ep;
        m = 8'hFF >> (3 - len);
        setcfg(len, pm, odd, 4'd7);
        ep = (pm == 2'd1) ? odd : ((^(a & m)) ^ odd);
        fork
            get_frame(req, int'(len) + 5, pm < 2'd2, 120, d, p, s);
            put(a, 1);
        join
        chk({req, " data"}, int'(d), int'(a & m));
        if (pm < 2'd2) chk({req, " parity bit"}, int'(p), int'(ep));
        else chk({req, " no parity, stop follows data"}, s, 120);
    endtask

    task automatic t_off_write();
        int lows = 0;
        pulse(1);
        put(8'h55, 0);
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R7 line idle while off", lows, 0);
        chk("R7 emt while off", int'(tx_emt), 1);
        pulse(0);
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R7 dropped write not sent", lows, 0);
        chk("R7 emt after on", int'(tx_emt), 1);
    endtask

    task automatic t_off_midchar();
        logic [7:0] d; logic p; int s;
        setcfg(2'd3, 2'd2, 1'b0, 4'd7);
        fork
            get_frame("R8", 8, 0, 600, d, p, s);
            begin
                put(8'h96, 1); put(8'h69, 1);
                while (txd !== 1'b0) @(negedge clk);
                pulse(1);
            end
        join
        chk("R8 frame in flight finishes", int'(d), 8'h96);
        chk("R8 held char not started", s, 600);
        chk("R8 emt with char held", int'(tx_emt), 0);
        chk("R8 rdy while off", int'(tx_rdy), 0);
        pulse(2);
        chk("R9 reset empties hold", int'(tx_emt), 1);
        pulse(0);
    endtask

    task automatic t_reset_cmd();
        int lows = 0;
        put(8'h00, 1);
        while (txd !== 1'b0) @(negedge clk);
        repeat (10) @(negedge clk);
        pulse(2);
        chk("R9 line high after reset", int'(txd), 1);
        chk("R9 emt after reset", int'(tx_emt), 1);
        repeat (200) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R9 stays idle", lows, 0);
    endtask

    task automatic t_cts();
        logic [7:0] d; logic p; int s; int lows = 0;
        cfg_cts_en = 1'b1; cts_i = 1'b0;
        put(8'hA7, 1);
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R12 no start without cts", lows, 0);
        chk("R12 char still held", int'(tx_rdy), 0);
        cts_i = 1'b1;
        get_frame("R12", 8, 0, 120, d, p, s);
        chk("R12 char sent once cts", int'(d), 8'hA7);
        cfg_cts_en = 1'b0;
    endtask

    task automatic t_break();
        logic [7:0] d; logic p; int s; int highs = 0; int t = 0;
        setcfg(2'd3, 2'd2, 1'b0, 4'd7);
        fork
            get_frame("R10", 8, 0, 600, d, p, s);
            begin
                put(8'h5A, 1); put(8'hE1, 1);
                while (txd !== 1'b0) @(negedge clk);
                repeat (5) @(negedge clk);
                pulse(3);
            end
        join
        chk("R10 current char intact", int'(d), 8'h5A);
        chk("R10 full stop before break", s, BIT_CYC);
        repeat (600) begin if (txd !== 1'b0) highs++; @(negedge clk); end
        chk("R10 line held low", highs, 0);
        pulse(4);
        while (txd !== 1'b1 && t < 20) begin @(negedge clk); t++; end
        highs = 0;
        while (txd === 1'b1 && highs < 600) begin highs++; @(negedge clk); end
        chk("R11 one bit high after break", highs, BIT_CYC);
        get_frame("R11", 8, 0, 120, d, p, s);
        chk("R11 resumes with next char", int'(d), 8'hE1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ready_flags();
        t_pair("R4 code0 8bit", 2'd3, 4'd0, 8'hA5, 8'h5A, 9 * TICK_DIV);
        t_pair("R4 code7 8bit", 2'd3, 4'd7, 8'h01, 8'h80, 16 * TICK_DIV);
        t_pair("R4 code8 8bit", 2'd3, 4'd8, 8'hF0, 8'h0F, 25 * TICK_DIV);
        t_pair("R4 code15 8bit", 2'd3, 4'd15, 8'h33, 8'hCC, 32 * TICK_DIV);
        t_pair("R4 code3 6bit", 2'd1, 4'd3, 8'hFF, 8'h2A, 12 * TICK_DIV);
        t_pair("R5 code0 5bit", 2'd0, 4'd0, 8'hFF, 8'h15, 17 * TICK_DIV);
        t_pair("R5 code7 5bit", 2'd0, 4'd7, 8'h0A, 8'h11, 24 * TICK_DIV);
        t_pair("R5 code8 5bit unchanged", 2'd0, 4'd8, 8'h1E, 8'h01, 25 * TICK_DIV);
        t_parity("R3 even 7bit", 2'd2, 2'd0, 1'b0, 8'h35);
        t_parity("R3 odd 7bit", 2'd2, 2'd0, 1'b1, 8'h35);
        t_parity("R3 even 8bit", 2'd3, 2'd0, 1'b0, 8'h07);
        t_parity("R3 fixed 0", 2'd3, 2'd1, 1'b0, 8'h01);
        t_parity("R3 fixed 1", 2'd3, 2'd1, 1'b1, 8'h00);
        t_parity("R3 none mode3", 2'd3, 2'd3, 1'b1, 8'hB4);
        t_off_write();
        t_off_midchar();
        t_reset_cmd();
        t_cts();
        t_break();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule